// File: doc/BRIEF.md
# Raw NAND Flash Target Emulator

This block stands in for a raw NAND flash device on the asynchronous eight-bit NAND bus, so that a host flash controller can identify it and boot from it. It oversamples the chip-enable, command-latch, address-latch, write-strobe and read-strobe pins and the data bus with the system clock. It decodes a small command set: reset, identify, parameter page, page read and status. It drives the data bus back through a separate output-enable, and it drives the open-drain style ready/busy line as a plain output.

Page contents live in an internal byte buffer that is filled through a simple write port. A page read ignores the row and column address and streams the buffer from its first byte, so the data and spare areas come out as one stream. The 256-byte parameter page is built from a set of loadable geometry registers, and its checksum is computed while the page is being read out. A page read always produces a busy pulse of configurable length, because some host controllers will not finish a read without one.

Top module: `onfi_nand_target`

## Requirements
- R1: After the synchronous reset the ready/busy output is high (ready) and the data output-enable is low.
- R2: Identify (opcode 0x90) followed by address 0x00 returns the manufacturer byte (loadable, 0x5A after reset) and then the device byte 0xDA.
- R3: Identify followed by address 0x20 returns the four signature bytes 0x4F, 0x4E, 0x46, 0x49.
- R4: Opcode 0xEC followed by one address byte selects the 256-byte parameter page: signature in bytes 0 to 3, 0x02 in byte 4, data bytes per page (32 bits) at 80, spare bytes per page (16 bits) at 84, pages per block (32 bits) at 92, blocks per unit (32 bits) at 96, all little-endian, 0x01 at byte 100, zero elsewhere. After reset these fields hold 2048, 64, 64 and 1024; a load strobe replaces them.
- R5: Bytes 254 and 255 hold, low byte first, a CRC-16 (polynomial 0x8005, seed 0x4F4E, most significant bit first, no reflection) over bytes 0 to 253; the byte read after byte 255 is byte 0 again.
- R6: Opcode 0x00, any number of address bytes, then 0x30 drives ready/busy low for exactly N clock cycles, where N is the loaded busy length (0 counts as 1, 16 after reset); page data is not driven while busy.
- R7: Page data starts at buffer index 0 regardless of the address bytes, advances by one byte for each falling read strobe, and wraps from the last buffer index to 0.
- R8: Opcode 0x70 selects the status byte: 0x40 when ready, 0x00 while busy; bit 0 is always 0 and it can be read during the busy pulse.
- R9: An opcode outside the decoded set leaves the current output stream and its position unchanged.
- R10: Opcode 0xFF stops any output stream, drives ready/busy low for 8 cycles and leaves no output selected.
- R11: Strobes while chip-enable is high are ignored, and the output-enable is high only while chip-enable and the read strobe are both low with an output selected.
- R12: Opcode 0x00 issued after a status read resumes page output at the current stream position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| nand_ce_n | input | 1 | Chip enable, active low |
| nand_cle | input | 1 | Command latch enable |
| nand_ale | input | 1 | Address latch enable |
| nand_we_n | input | 1 | Write strobe, bytes taken on its rising edge |
| nand_re_n | input | 1 | Read strobe, data advances on its falling edge |
| nand_io_in | input | 8 | Data bus as seen from the pins |
| nand_io_out | output | 8 | Data driven toward the host |
| nand_io_oe | output | 1 | Output enable for the data bus |
| nand_rb_n | output | 1 | Ready (high) or busy (low) |
| buf_wr_en | input | 1 | Buffer write strobe |
| buf_wr_addr | input | AW | Buffer write index |
| buf_wr_data | input | 8 | Buffer write byte |
| cfg_load | input | 1 | Loads all cfg_ inputs into the geometry registers |
| cfg_page_bytes | input | 32 | Data bytes per page |
| cfg_spare_bytes | input | 16 | Spare bytes per page |
| cfg_block_pages | input | 32 | Pages per block |
| cfg_lun_blocks | input | 32 | Blocks per unit |
| cfg_mfr_id | input | 8 | Manufacturer byte returned by identify |
| cfg_busy_len | input | 16 | Busy pulse length after 0x30, in cycles |

## Verification
A wrong command or output-mode state shows on the very next read strobe as a wrong byte or a missing output-enable, so every read in the bench is compared against a byte computed from the requirements. A corrupt checksum register shows only at bytes 254 and 255, which is why full parameter pages are read under several random geometries. A wrong busy counter shows as a ready/busy pulse of the wrong length, measured cycle by cycle, and a wrong stream pointer shows within one buffer length through the wrap check.

// File: rtl/onfi_emu_pkg.sv
package onfi_emu_pkg;

    localparam logic [7:0] OP_RESET   = 8'hFF;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_PARAM   = 8'hEC;
    localparam logic [7:0] OP_READ    = 8'h00;
    localparam logic [7:0] OP_READ_GO = 8'h30;
    localparam logic [7:0] OP_STATUS  = 8'h70;

    localparam logic [15:0] CRC_POLY = 16'h8005;
    localparam logic [15:0] CRC_SEED = 16'h4F4E;
    localparam logic [7:0]  CRC_LO_IDX = 8'd254;

    localparam logic [7:0] ST_READY = 8'h40;
    localparam logic [7:0] ST_BUSY  = 8'h00;

    typedef struct packed {
        logic [31:0] page_bytes;
        logic [15:0] spare_bytes;
        logic [31:0] block_pages;
        logic [31:0] lun_blocks;
        logic [7:0]  mfr_id;
        logic [15:0] busy_len;
    } geom_t;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_ID_ADDR,
        CS_PP_ADDR,
        CS_RD_ADDR
    } cmd_state_e;

    typedef enum logic [2:0] {
        OM_NONE,
        OM_ID,
        OM_PARAM,
        OM_PAGE,
        OM_STATUS
    } out_mode_e;

    // One byte of checksum update, most significant bit first.
    function automatic logic [15:0] crc16_byte(input logic [15:0] crc_in,
                                               input logic [7:0]  data);
        logic [15:0] c;
        c = crc_in;
        for (int b = 7; b >= 0; b--) begin
            if (c[15] ^ data[b]) c = {c[14:0], 1'b0} ^ CRC_POLY;
            else                 c = {c[14:0], 1'b0};
        end
        return c;
    endfunction

    // Parameter page body, checksum bytes excluded.
    function automatic logic [7:0] param_body(input logic [7:0] idx,
                                              input geom_t g);
        case (idx)
            8'd0:    return 8'h4F;
            8'd1:    return 8'h4E;
            8'd2:    return 8'h46;
            8'd3:    return 8'h49;
            8'd4:    return 8'h02;
            8'd80:   return g.page_bytes[7:0];
            8'd81:   return g.page_bytes[15:8];
            8'd82:   return g.page_bytes[23:16];
            8'd83:   return g.page_bytes[31:24];
            8'd84:   return g.spare_bytes[7:0];
            8'd85:   return g.spare_bytes[15:8];
            8'd92:   return g.block_pages[7:0];
            8'd93:   return g.block_pages[15:8];
            8'd94:   return g.block_pages[23:16];
            8'd95:   return g.block_pages[31:24];
            8'd96:   return g.lun_blocks[7:0];
            8'd97:   return g.lun_blocks[15:8];
            8'd98:   return g.lun_blocks[23:16];
            8'd99:   return g.lun_blocks[31:24];
            8'd100:  return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/onfi_pin_sync.sv
module onfi_pin_sync #(
    parameter int          W       = 8,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] r;
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) r <= RST_VAL;
                else     r <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) r <= RST_VAL;
                else     r <= g_stage[g-1].r;
            end
        end
    end

    assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/onfi_page_buf.sv
module onfi_page_buf #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/onfi_param_gen.sv
module onfi_param_gen
    import onfi_emu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  geom_t      geom,
    input  logic       restart,
    input  logic       advance,
    output logic [7:0] byte_now
);
    logic [7:0]  ptr;
    logic [15:0] crc;
    logic [7:0]  body;

    assign body = param_body(ptr, geom);

    always_comb begin
        if (ptr < CRC_LO_IDX)      byte_now = body;
        else if (ptr == CRC_LO_IDX) byte_now = crc[7:0];
        else                        byte_now = crc[15:8];
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            ptr <= '0;
            crc <= CRC_SEED;
        end else if (advance) begin
            ptr <= ptr + 8'd1;
            if (ptr < CRC_LO_IDX)     crc <= crc16_byte(crc, body);
            else if (ptr == 8'd255)   crc <= CRC_SEED;
        end
    end

    // R5: a new pass over the page starts from the seed
    assert_crc_reseed_R5: assert property (@(posedge clk) disable iff (rst)
        (advance && !restart && ptr == 8'd255) |=> (ptr == 8'd0 && crc == CRC_SEED));
endmodule

// File: rtl/onfi_nand_target.sv
module onfi_nand_target
    import onfi_emu_pkg::*;
#(
    parameter int          DEPTH           = 256,
    parameter int          SYNC_STAGES     = 2,
    parameter int          RST_BUSY        = 8,
    parameter logic [31:0] DEF_PAGE_BYTES  = 32'd2048,
    parameter logic [15:0] DEF_SPARE_BYTES = 16'd64,
    parameter logic [31:0] DEF_BLOCK_PAGES = 32'd64,
    parameter logic [31:0] DEF_LUN_BLOCKS  = 32'd1024,
    parameter logic [7:0]  DEF_MFR_ID      = 8'h5A,
    parameter logic [7:0]  DEV_ID          = 8'hDA,
    parameter logic [15:0] DEF_BUSY_LEN    = 16'd16,
    localparam int         AW              = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          nand_ce_n,
    input  logic          nand_cle,
    input  logic          nand_ale,
    input  logic          nand_we_n,
    input  logic          nand_re_n,
    input  logic [7:0]    nand_io_in,
    output logic [7:0]    nand_io_out,
    output logic          nand_io_oe,
    output logic          nand_rb_n,
    input  logic          buf_wr_en,
    input  logic [AW-1:0] buf_wr_addr,
    input  logic [7:0]    buf_wr_data,
    input  logic          cfg_load,
    input  logic [31:0]   cfg_page_bytes,
    input  logic [15:0]   cfg_spare_bytes,
    input  logic [31:0]   cfg_block_pages,
    input  logic [31:0]   cfg_lun_blocks,
    input  logic [7:0]    cfg_mfr_id,
    input  logic [15:0]   cfg_busy_len
);
    localparam int PIN_W = 13;
    localparam logic [PIN_W-1:0] PIN_IDLE = {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00};
    localparam logic [15:0] RST_BUSY_LEN = 16'(RST_BUSY);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    // Pin oversampling and strobe edges
    logic [PIN_W-1:0] pins_s;
    logic ce_s, cle_s, ale_s, we_s, re_s;
    logic [7:0] io_s;
    logic we_q, re_q;

    onfi_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_in}),
        .q   (pins_s)
    );

    assign {ce_s, cle_s, ale_s, we_s, re_s, io_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q <= 1'b1;
            re_q <= 1'b1;
        end else begin
            we_q <= we_s;
            re_q <= re_s;
        end
    end

    logic we_rise, re_fall, re_rise, cmd_stb, adr_stb, rd_stb;
    assign we_rise = we_s & ~we_q;
    assign re_fall = ~re_s & re_q;
    assign re_rise = re_s & ~re_q;
    assign cmd_stb = we_rise & ~ce_s & cle_s & ~ale_s;
    assign adr_stb = we_rise & ~ce_s & ale_s & ~cle_s;
    assign rd_stb  = re_fall & ~ce_s;

    // Control state
    geom_t      geom;
    cmd_state_e cstate;
    out_mode_e  omode;
    logic       busy, busy_page;
    logic [15:0] busy_cnt;
    logic [AW-1:0] page_ptr;
    logic       id_onfi;
    logic [2:0] id_idx;

    // Data sources
    logic [7:0] param_byte, page_byte, id_byte;
    logic       param_restart, param_adv;

    assign param_restart = adr_stb && (cstate == CS_PP_ADDR);
    assign param_adv     = rd_stb && (omode == OM_PARAM);

    onfi_param_gen i_param (
        .clk      (clk),
        .rst      (rst),
        .geom     (geom),
        .restart  (param_restart),
        .advance  (param_adv),
        .byte_now (param_byte)
    );

    onfi_page_buf #(.DEPTH(DEPTH)) i_buf (
        .clk     (clk),
        .wr_en   (buf_wr_en),
        .wr_addr (buf_wr_addr),
        .wr_data (buf_wr_data),
        .rd_addr (page_ptr),
        .rd_data (page_byte)
    );

    always_comb begin
        id_byte = 8'h00;
        if (id_onfi) begin
            case (id_idx)
                3'd0: id_byte = 8'h4F;
                3'd1: id_byte = 8'h4E;
                3'd2: id_byte = 8'h46;
                3'd3: id_byte = 8'h49;
                default: id_byte = 8'h00;
            endcase
        end else begin
            case (id_idx)
                3'd0: id_byte = geom.mfr_id;
                3'd1: id_byte = DEV_ID;
                default: id_byte = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            geom        <= '{page_bytes: DEF_PAGE_BYTES, spare_bytes: DEF_SPARE_BYTES,
                             block_pages: DEF_BLOCK_PAGES, lun_blocks: DEF_LUN_BLOCKS,
                             mfr_id: DEF_MFR_ID, busy_len: DEF_BUSY_LEN};
            cstate      <= CS_IDLE;
            omode       <= OM_NONE;
            busy        <= 1'b0;
            busy_page   <= 1'b0;
            busy_cnt    <= '0;
            page_ptr    <= '0;
            id_onfi     <= 1'b0;
            id_idx      <= '0;
            nand_io_out <= 8'h00;
            nand_io_oe  <= 1'b0;
        end else begin
            if (cfg_load) begin
                geom <= '{page_bytes: cfg_page_bytes, spare_bytes: cfg_spare_bytes,
                          block_pages: cfg_block_pages, lun_blocks: cfg_lun_blocks,
                          mfr_id: cfg_mfr_id, busy_len: cfg_busy_len};
            end

            if (re_rise || ce_s) nand_io_oe <= 1'b0;

            // Busy timer
            if (busy) begin
                if (busy_cnt <= 16'd1) begin
                    busy      <= 1'b0;
                    busy_cnt  <= '0;
                    busy_page <= 1'b0;
                    if (busy_page && omode == OM_NONE) omode <= OM_PAGE;
                end else begin
                    busy_cnt <= busy_cnt - 16'd1;
                end
            end

            // Read strobe: present the next byte of the selected stream
            if (rd_stb) begin
                case (omode)
                    OM_ID: begin
                        nand_io_out <= id_byte;
                        nand_io_oe  <= 1'b1;
                        if (id_idx != 3'd7) id_idx <= id_idx + 3'd1;
                    end
                    OM_PARAM: begin
                        nand_io_out <= param_byte;
                        nand_io_oe  <= 1'b1;
                    end
                    OM_PAGE: begin
                        if (!busy) begin
                            nand_io_out <= page_byte;
                            nand_io_oe  <= 1'b1;
                            page_ptr    <= (page_ptr == LAST_IDX) ? '0 : page_ptr + 1'b1;
                        end
                    end
                    OM_STATUS: begin
                        nand_io_out <= busy ? ST_BUSY : ST_READY;
                        nand_io_oe  <= 1'b1;
                    end
                    default: ;
                endcase
            end

            // Command and address latching
            if (cmd_stb) begin
                case (io_s)
                    OP_RESET: begin
                        nand_io_oe <= 1'b0;
                        cstate     <= CS_IDLE;
                        omode      <= OM_NONE;
                        busy       <= 1'b1;
                        busy_page  <= 1'b0;
                        busy_cnt   <= RST_BUSY_LEN;
                    end
                    OP_IDENT: begin
                        nand_io_oe <= 1'b0;
                        cstate     <= CS_ID_ADDR;
                        omode      <= OM_NONE;
                    end
                    OP_PARAM: begin
                        nand_io_oe <= 1'b0;
                        cstate     <= CS_PP_ADDR;
                        omode      <= OM_NONE;
                    end
                    OP_READ: begin
                        nand_io_oe <= 1'b0;
                        cstate     <= CS_RD_ADDR;
                        omode      <= OM_PAGE;
                    end
                    OP_READ_GO: begin
                        if (cstate == CS_RD_ADDR) begin
                            nand_io_oe <= 1'b0;
                            cstate     <= CS_IDLE;
                            omode      <= OM_NONE;
                            busy       <= 1'b1;
                            busy_page  <= 1'b1;
                            busy_cnt   <= (geom.busy_len == 16'd0) ? 16'd1 : geom.busy_len;
                            page_ptr   <= '0;
                        end
                    end
                    OP_STATUS: begin
                        nand_io_oe <= 1'b0;
                        omode      <= OM_STATUS;
                    end
                    default: ;
                endcase
            end else if (adr_stb) begin
                case (cstate)
                    CS_ID_ADDR: begin
                        id_onfi <= (io_s == 8'h20);
                        id_idx  <= '0;
                        omode   <= (io_s == 8'h00 || io_s == 8'h20) ? OM_ID : OM_NONE;
                        cstate  <= CS_IDLE;
                    end
                    CS_PP_ADDR: begin
                        omode  <= OM_PARAM;
                        cstate <= CS_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign nand_rb_n = ~busy;

    // R11: the bus is only driven after a cycle with chip enable low
    assert_oe_needs_ce_R11: assert property (@(posedge clk) disable iff (rst)
        nand_io_oe |-> $past(!ce_s));

    // R6: while busy, only the status byte may be driven
    assert_busy_blocks_data_R6: assert property (@(posedge clk) disable iff (rst)
        (nand_io_oe && !nand_rb_n) |-> (omode == OM_STATUS));

    // R6: a busy pulse always has cycles left on its timer
    assert_busy_count_R6: assert property (@(posedge clk) disable iff (rst)
        !nand_rb_n |-> (busy_cnt != 16'd0));

    // R8: a driven status byte never reports failure
    assert_status_pass_R8: assert property (@(posedge clk) disable iff (rst)
        (nand_io_oe && omode == OM_STATUS) |-> !nand_io_out[0]);
endmodule

// File: tb/test_onfi_nand_target.sv
module test_onfi_nand_target;
    localparam int DEPTH = 256;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
    logic [7:0] io_in = 8'h00;
    logic [7:0] io_out;
    logic io_oe, rb_n;
    logic buf_wr_en = 1'b0;
    logic [AW-1:0] buf_wr_addr = '0;
    logic [7:0] buf_wr_data = 8'h00;
    logic cfg_load = 1'b0;
    logic [31:0] cfg_page_bytes = 32'd2048;
    logic [15:0] cfg_spare_bytes = 16'd64;
    logic [31:0] cfg_block_pages = 32'd64;
    logic [31:0] cfg_lun_blocks = 32'd1024;
    logic [7:0]  cfg_mfr_id = 8'h5A;
    logic [15:0] cfg_busy_len = 16'd16;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    int low_run = 0;
    int last_low = 0;
    logic [7:0] exp_mem [DEPTH];

    always #2 clk = ~clk;

    onfi_nand_target #(.DEPTH(DEPTH)) i_onfi_nand_target (
        .clk(clk), .rst(rst),
        .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n),
        .nand_io_in(io_in), .nand_io_out(io_out), .nand_io_oe(io_oe), .nand_rb_n(rb_n),
        .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data),
        .cfg_load(cfg_load), .cfg_page_bytes(cfg_page_bytes), .cfg_spare_bytes(cfg_spare_bytes),
        .cfg_block_pages(cfg_block_pages), .cfg_lun_blocks(cfg_lun_blocks),
        .cfg_mfr_id(cfg_mfr_id), .cfg_busy_len(cfg_busy_len)
    );

    // Busy pulse length monitor
    always @(negedge clk) begin
        if (rb_n === 1'b0) low_run <= low_run + 1;
        else if (low_run != 0) begin
            last_low <= low_run;
            low_run  <= 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [7:0] b);
        cle = 1'b1; io_in = b;
        repeat (2) @(posedge clk);
        we_n = 1'b0;
        repeat (3) @(posedge clk);
        we_n = 1'b1;
        repeat (4) @(posedge clk);
        cle = 1'b0;
    endtask

    task automatic adr(input logic [7:0] b);
        ale = 1'b1; io_in = b;
        repeat (2) @(posedge clk);
        we_n = 1'b0;
        repeat (3) @(posedge clk);
        we_n = 1'b1;
        repeat (4) @(posedge clk);
        ale = 1'b0;
    endtask

    task automatic rd(output logic oe, output logic [7:0] d);
        re_n = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        oe = io_oe; d = io_out;
        re_n = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    task automatic load_cfg();
        @(negedge clk); cfg_load = 1'b1;
        @(negedge clk); cfg_load = 1'b0;
    endtask

    task automatic wait_ready();
        int guard = 0;
        repeat (2) @(posedge clk);
        while (rb_n !== 1'b1 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(posedge clk);
    endtask

    function automatic logic [7:0] exp_body(input int i);
        case (i)
            0: return 8'h4F;  1: return 8'h4E;  2: return 8'h46;  3: return 8'h49;
            4: return 8'h02;
            80, 81, 82, 83: return cfg_page_bytes[8*(i-80) +: 8];
            84, 85:         return cfg_spare_bytes[8*(i-84) +: 8];
            92, 93, 94, 95: return cfg_block_pages[8*(i-92) +: 8];
            96, 97, 98, 99: return cfg_lun_blocks[8*(i-96) +: 8];
            100: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [15:0] exp_crc();
        logic [15:0] c = 16'h4F4E;
        for (int i = 0; i < 254; i++) begin
            logic [7:0] v = exp_body(i);
            for (int b = 7; b >= 0; b--) begin
                logic top = c[15] ^ v[b];
                c = c << 1;
                if (top) c = c ^ 16'h8005;
            end
        end
        return c;
    endfunction

    task automatic check_param_page();
        logic oe; logic [7:0] d;
        logic [15:0] crc = exp_crc();
        cmd(8'hEC); adr(8'h00);
        for (int i = 0; i < 254; i++) begin
            rd(oe, d);
            chk("R4 param byte", {23'd0, oe, d}, {23'd0, 1'b1, exp_body(i)});
        end
        rd(oe, d); chk("R5 crc low", d, crc[7:0]);
        rd(oe, d); chk("R5 crc high", d, crc[15:8]);
        rd(oe, d); chk("R5 wrap to byte 0", d, 8'h4F);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic oe; logic [7:0] d;
        void'($urandom(32'h1F2E3D4C));
        repeat (6) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", rb_n, 1);
        chk("R1 no drive after reset", io_oe, 0);

        // Buffer fill
        for (int i = 0; i < DEPTH; i++) begin
            exp_mem[i] = 8'($urandom);
            @(negedge clk);
            buf_wr_en = 1'b1; buf_wr_addr = AW'(i); buf_wr_data = exp_mem[i];
        end
        @(negedge clk); buf_wr_en = 1'b0;

        ce_n = 1'b0;
        // Identify
        cmd(8'h90); adr(8'h00);
        rd(oe, d); chk("R2 default mfr", {oe, d}, {1'b1, 8'h5A});
        rd(oe, d); chk("R2 device byte", d, 8'hDA);
        cmd(8'h90); adr(8'h20);
        rd(oe, d); chk("R3 sig 0", d, 8'h4F);
        rd(oe, d); chk("R3 sig 1", d, 8'h4E);

        // Chip enable gating
        ce_n = 1'b1;
        rd(oe, d); chk("R11 no drive with CE high", oe, 0);
        cmd(8'hFF);
        chk("R11 reset ignored with CE high", last_low, 0);
        ce_n = 1'b0;
        rd(oe, d); chk("R3 sig 2 after ignored strobes", d, 8'h46);
        rd(oe, d); chk("R3 sig 3", d, 8'h49);

        // Parameter page with defaults
        check_param_page();

        // Unknown opcode
        cmd(8'hEC); adr(8'h00);
        rd(oe, d); rd(oe, d);
        cmd(8'h55);
        rd(oe, d); chk("R9 stream continues", {oe, d}, {1'b1, 8'h46});

        // Random geometries
        for (int r = 0; r < 3; r++) begin
            cfg_page_bytes  = $urandom;
            cfg_spare_bytes = 16'($urandom);
            cfg_block_pages = $urandom;
            cfg_lun_blocks  = $urandom;
            cfg_mfr_id      = 8'($urandom);
            cfg_busy_len    = 16'($urandom_range(5, 40));
            load_cfg();
            check_param_page();
            cmd(8'h90); adr(8'h00);
            rd(oe, d); chk("R2 loaded mfr", d, cfg_mfr_id);
        end

        // Page read
        cmd(8'h00);
        for (int a = 0; a < 5; a++) adr(8'($urandom));
        cmd(8'h30);
        wait_ready();
        chk("R6 busy length", last_low, cfg_busy_len);
        for (int i = 0; i < DEPTH + 2; i++) begin
            rd(oe, d);
            chk("R7 page byte", {23'd0, oe, d}, {23'd0, 1'b1, exp_mem[i % DEPTH]});
        end

        // Zero busy length
        cfg_busy_len = 16'd0; load_cfg();
        cmd(8'h00); adr(8'h12); cmd(8'h30);
        wait_ready();
        chk("R6 zero length counts as one", last_low, 1);
        rd(oe, d); chk("R7 restart at index 0", d, exp_mem[0]);

        // Status during a long busy pulse
        cfg_busy_len = 16'd300; load_cfg();
        cmd(8'h00); adr(8'h01); adr(8'h02); cmd(8'h30);
        rd(oe, d); chk("R6 no data while busy", oe, 0);
        cmd(8'h70);
        rd(oe, d); chk("R8 status busy", {oe, d}, {1'b1, 8'h00});
        wait_ready();
        chk("R6 long busy length", last_low, 300);
        rd(oe, d); chk("R8 status ready", {oe, d}, {1'b1, 8'h40});
        cmd(8'h00);
        for (int i = 0; i < 3; i++) begin
            rd(oe, d); chk("R12 resume page", {oe, d}, {1'b1, exp_mem[i]});
        end
        cmd(8'h70);
        rd(oe, d);
        cmd(8'h00);
        rd(oe, d); chk("R12 resume keeps position", d, exp_mem[3]);

        // Reset command
        cmd(8'hFF);
        wait_ready();
        chk("R10 reset busy length", last_low, 8);
        rd(oe, d); chk("R10 no output after reset", oe, 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule